// File: doc/BRIEF.md
# External Bus Reset Access Gate

This block stands between the internal bus masters and the engine that drives external memory cycles. It decides which external cycle may begin and when, based on two separate reset inputs. A power-on reset, active low and asynchronous, returns every register to its initial value at once. It also clears a first-access delay counter.

After that reset, normal accesses are held off until the counter has saturated. This gives slow memories a settling time before the first access. A manual reset is gentler. The cycle already running is allowed to finish, and a burst is cut short at the next word. New master accesses are then refused. Refresh and external bus-request arbitration carry on as before. The delay counter is not touched, so accesses resume as soon as manual reset drops.

Masters use a valid/ready handshake. The engine reports the end of each 32-bit word on `word_done` and watches `cyc_active` to see how long the current cycle lasts.

Top module: `ebus_rst_gate`

## Requirements
- R1: While `por_n` is low, `cyc_active`, `bgnt`, `bus_oe` and `req_ready` are 0. This takes effect immediately, even in the middle of a cycle and without a clock edge. `bus_oe` goes to 1 on the first clock edge after release.
- R2: The first-access counter is 5 bits wide. Power-on reset sets it to 0. It then increments on every rising clock edge and stays at 31 once it gets there.
- R3: `req_ready` stays 0 until the counter reads 31, which is after 31 clock edges following power-on release. A request with `req_valid` high stays pending, without being lost, until `req_ready` is 1. It is accepted on the edge where `req_valid` and `req_ready` are both high.
- R4: An accepted request starts an access cycle: `cyc_active`=1, `cyc_kind`=2'b01, and `cyc_burst` equal to `req_burst`. A single access lasts for 1 `word_done`; a burst lasts for 4. `cyc_active` returns to 0 on the edge that samples the final `word_done`.
- R5: While `mrst` is high, a cycle that is already running goes on to its normal end, and `req_ready` is 0. Manual reset leaves the delay counter alone, so `req_ready` is 1 in the first cycle with `mrst` low.
- R6: If `mrst` is high when a burst samples `word_done`, the burst ends on that edge. No further words are run.
- R7: A refresh request (`ref_req`) is still served during manual reset. `ref_ack` is a combinational pulse in the idle cycle that picks it. A refresh cycle shows `cyc_kind`=2'b10 and ends at one `word_done`.
- R8: An external bus request (`breq`) is still granted during manual reset. `bgnt`=1 and `bus_oe`=0 for as long as `breq` stays high. `bus_oe` returns to 1 on the edge where `breq` is seen low.
- R9: When idle, the block picks refresh first, then the external bus request, then a master access. A running cycle is never pre-empted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst | input | 1 | Manual reset, active high, sampled |
| req_valid | input | 1 | Master access request pending |
| req_burst | input | 1 | 1 = 4-word burst, 0 = single word |
| req_ready | output | 1 | Access may be accepted this cycle |
| ref_req | input | 1 | Refresh wanted (level) |
| ref_ack | output | 1 | Refresh taken this cycle |
| breq | input | 1 | External master wants the bus |
| bgnt | output | 1 | Bus handed to external master |
| word_done | input | 1 | Engine finished one 32-bit word |
| cyc_active | output | 1 | Access or refresh cycle running |
| cyc_kind | output | 2 | 00 none, 01 access, 10 refresh |
| cyc_burst | output | 1 | Running access is a burst |
| bus_oe | output | 1 | Block drives external bus outputs |

## Verification
The bench sweeps every cycle count after power-on release. A counter that is off by one would raise `req_ready`, or start the held request, one edge too early or too late. It also cuts a burst at each of its four words in turn. A design that ignored manual reset would keep running words, and one that cut too soon would end before the current word had finished. Manual reset is checked at both ends. Accesses must be refused during it but resume at once afterwards; a design that cleared the counter would stay blocked for 31 more cycles. Refresh, bus grant and the three-way priority are exercised during manual reset. A power-on reset is applied mid-burst to show that the outputs drop with no clock edge.

// File: rtl/ebus_gate_pkg.sv
package ebus_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_REF  = 2'd2,
        ST_BUS  = 2'd3
    } gate_st_e;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_REF  = 2'd1,
        PK_BUS  = 2'd2,
        PK_ACC  = 2'd3
    } pick_e;

    localparam logic [1:0] KIND_NONE = 2'b00;
    localparam logic [1:0] KIND_ACC  = 2'b01;
    localparam logic [1:0] KIND_REF  = 2'b10;

endpackage

// File: rtl/ebus_dly_ctr.sv
module ebus_dly_ctr #(
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic por_n,
    output logic warm
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign warm = (cnt_q == CNT_MAX);

    // R2: counting and saturation
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!por_n)
        (cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/ebus_pick.sv
module ebus_pick
    import ebus_gate_pkg::*;
(
    input  logic  idle,
    input  logic  ref_req,
    input  logic  breq,
    input  logic  acc_ok,
    input  logic  req_valid,
    output logic  ready,
    output pick_e pick
);
    always_comb begin
        ready = idle && !ref_req && !breq && acc_ok;
        pick  = PK_NONE;
        if (idle) begin
            if (ref_req)                 pick = PK_REF;
            else if (breq)               pick = PK_BUS;
            else if (ready && req_valid) pick = PK_ACC;
        end
    end
endmodule

// File: rtl/ebus_rst_gate.sv
module ebus_rst_gate
    import ebus_gate_pkg::*;
#(
    parameter int DLY_W       = 5,
    parameter int BURST_WORDS = 4
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       mrst,
    input  logic       req_valid,
    input  logic       req_burst,
    output logic       req_ready,
    input  logic       ref_req,
    output logic       ref_ack,
    input  logic       breq,
    output logic       bgnt,
    input  logic       word_done,
    output logic       cyc_active,
    output logic [1:0] cyc_kind,
    output logic       cyc_burst,
    output logic       bus_oe
);
    localparam int LEFT_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
    localparam logic [LEFT_W-1:0] LAST_IDX = LEFT_W'(BURST_WORDS - 1);

    typedef struct packed {
        gate_st_e          st;
        logic [LEFT_W-1:0] left;
        logic              burst;
        logic              oe;
    } gate_regs_t;

    gate_regs_t r_d, r_q;
    logic       warm;
    logic       ready_w;
    pick_e      pick;

    ebus_dly_ctr #(.CNT_W(DLY_W)) u_dly (
        .clk   (clk),
        .por_n (por_n),
        .warm  (warm)
    );

    ebus_pick u_pick (
        .idle      (r_q.st == ST_IDLE),
        .ref_req   (ref_req),
        .breq      (breq),
        .acc_ok    (warm && !mrst),
        .req_valid (req_valid),
        .ready     (ready_w),
        .pick      (pick)
    );

    always_comb begin
        r_d     = r_q;
        ref_ack = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                unique case (pick)
                    PK_REF: begin
                        r_d.st  = ST_REF;
                        ref_ack = 1'b1;
                    end
                    PK_BUS: r_d.st = ST_BUS;
                    PK_ACC: begin
                        r_d.st    = ST_ACC;
                        r_d.burst = req_burst;
                        r_d.left  = req_burst ? LAST_IDX : '0;
                    end
                    default: ;
                endcase
            end
            ST_ACC: begin
                if (word_done) begin
                    if (r_q.left == '0 || mrst) begin
                        r_d.st    = ST_IDLE;
                        r_d.burst = 1'b0;
                        r_d.left  = '0;
                    end else begin
                        r_d.left = r_q.left - 1'b1;
                    end
                end
            end
            ST_REF: if (word_done) r_d.st = ST_IDLE;
            ST_BUS: if (!breq)     r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
        r_d.oe = (r_d.st != ST_BUS);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q.st    <= ST_IDLE;
            r_q.left  <= '0;
            r_q.burst <= 1'b0;
            r_q.oe    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = ready_w;
    assign bgnt       = (r_q.st == ST_BUS);
    assign cyc_active = (r_q.st == ST_ACC) || (r_q.st == ST_REF);
    assign cyc_kind   = (r_q.st == ST_ACC) ? KIND_ACC :
                        (r_q.st == ST_REF) ? KIND_REF : KIND_NONE;
    assign cyc_burst  = (r_q.st == ST_ACC) && r_q.burst;
    assign bus_oe     = r_q.oe;

    // R1: power-on reset silences the bus at once
    assert_por_quiet_R1: assert property (@(posedge clk)
        !por_n |-> (!bus_oe && !cyc_active && !bgnt));
    // R3: no access accepted before the delay counter saturates
    assert_warm_gate_R3: assert property (@(posedge clk) disable iff (!por_n)
        (req_valid && req_ready) |-> warm);
    // R5: no new access begins while manual reset is high
    assert_no_acc_mrst_R5: assert property (@(posedge clk) disable iff (!por_n)
        (mrst && r_q.st != ST_ACC) |=> (r_q.st != ST_ACC));
    // R6: burst ends at the word boundary seen under manual reset
    assert_burst_cut_R6: assert property (@(posedge clk) disable iff (!por_n)
        (r_q.st == ST_ACC && mrst && word_done) |=> (r_q.st == ST_IDLE));
    // R9: refresh wins arbitration when idle
    assert_ref_first_R9: assert property (@(posedge clk) disable iff (!por_n)
        (r_q.st == ST_IDLE && ref_req) |=> (r_q.st == ST_REF));
    // R8: bus request granted ahead of access, whatever mrst does
    assert_bus_grant_R8: assert property (@(posedge clk) disable iff (!por_n)
        (r_q.st == ST_IDLE && breq && !ref_req) |=> (bgnt && !bus_oe));

endmodule

// File: tb/ebus_rst_gate_tb.sv
module ebus_rst_gate_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       mrst = 1'b0, req_valid = 1'b0, req_burst = 1'b0;
    logic       ref_req = 1'b0, breq = 1'b0, word_done = 1'b0;
    logic       req_ready, ref_ack, bgnt, cyc_active, cyc_burst, bus_oe;
    logic [1:0] cyc_kind;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ebus_rst_gate u_dut (
        .clk(clk), .por_n(por_n), .mrst(mrst),
        .req_valid(req_valid), .req_burst(req_burst), .req_ready(req_ready),
        .ref_req(ref_req), .ref_ack(ref_ack), .breq(breq), .bgnt(bgnt),
        .word_done(word_done), .cyc_active(cyc_active), .cyc_kind(cyc_kind),
        .cyc_burst(cyc_burst), .bus_oe(bus_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic word();
        word_done = 1'b1;
        step();
        word_done = 1'b0;
        #1;
    endtask

    task automatic por_cycle(input bit hold_req);
        por_n = 1'b0;
        #1;
        chk("R1 oe at por", bus_oe, 0);
        chk("R1 active at por", cyc_active, 0);
        chk("R1 bgnt at por", bgnt, 0);
        req_valid = hold_req;
        req_burst = 1'b0;
        step();
        step();
        por_n = 1'b1;
        #1;
        chk("R1 ready after release", req_ready, 0);
        for (int k = 1; k <= 33; k++) begin
            step();
            #1;
            if (k == 1) chk("R1 oe back", bus_oe, 1);
            if (hold_req) begin
                chk("R3 held request start", cyc_active, (k >= 32) ? 1 : 0);
                chk("R2 counter reach ready", req_ready, (k == 31) ? 1 : 0);
            end else begin
                chk("R3 ready vs counter", req_ready, (k >= 31) ? 1 : 0);
            end
        end
        if (hold_req) begin
            chk("R4 kind access", cyc_kind, 1);
            req_valid = 1'b0;
            word();
            chk("R4 single ends", cyc_active, 0);
        end
    endtask

    task automatic start_acc(input bit b);
        req_valid = 1'b1;
        req_burst = b;
        #1;
        chk("R3 ready before start", req_ready, 1);
        step();
        req_valid = 1'b0;
        #1;
        chk("R4 active", cyc_active, 1);
        chk("R4 kind", cyc_kind, 1);
        chk("R4 burst flag", cyc_burst, b);
    endtask

    initial begin
        #3;
        por_cycle(1'b0);

        // R4 single access
        start_acc(1'b0);
        step();
        #1;
        chk("R4 waits for word", cyc_active, 1);
        word();
        chk("R4 single done", cyc_active, 0);

        // R4 full burst
        start_acc(1'b1);
        for (int w = 0; w < 4; w++) begin
            word();
            chk("R4 burst progress", cyc_active, (w < 3) ? 1 : 0);
        end

        // R6 cut at each word, then R5 hold and resume
        for (int j = 0; j < 4; j++) begin
            start_acc(1'b1);
            for (int w = 0; w <= j; w++) begin
                if (w == j) mrst = 1'b1;
                word();
                chk("R6 burst cut", cyc_active, (w < j) ? 1 : 0);
            end
            req_valid = 1'b1;
            req_burst = 1'b0;
            #1;
            chk("R5 ready low in mrst", req_ready, 0);
            step();
            step();
            #1;
            chk("R5 no access in mrst", cyc_active, 0);
            mrst = 1'b0;
            #1;
            chk("R5 resume at once", req_ready, 1);
            step();
            req_valid = 1'b0;
            #1;
            chk("R5 held request served", cyc_kind, 1);
            word();
        end

        // R5 single completes under mrst
        start_acc(1'b0);
        mrst = 1'b1;
        step();
        step();
        #1;
        chk("R5 in-flight kept", cyc_active, 1);
        word();
        chk("R5 in-flight ends", cyc_active, 0);

        // R7 refresh under mrst
        ref_req = 1'b1;
        #1;
        chk("R7 ref_ack pulse", ref_ack, 1);
        step();
        ref_req = 1'b0;
        #1;
        chk("R7 refresh kind", cyc_kind, 2);
        chk("R7 ack one cycle", ref_ack, 0);
        word();
        chk("R7 refresh ends", cyc_active, 0);

        // R8 bus request under mrst
        breq = 1'b1;
        step();
        #1;
        chk("R8 bgnt in mrst", bgnt, 1);
        chk("R8 oe released", bus_oe, 0);
        step();
        #1;
        chk("R8 grant held", bgnt, 1);
        breq = 1'b0;
        step();
        #1;
        chk("R8 grant dropped", bgnt, 0);
        chk("R8 oe back", bus_oe, 1);
        mrst = 1'b0;

        // R9 priority
        ref_req = 1'b1;
        breq = 1'b1;
        req_valid = 1'b1;
        req_burst = 1'b0;
        #1;
        chk("R9 access blocked", req_ready, 0);
        chk("R9 refresh chosen", ref_ack, 1);
        step();
        ref_req = 1'b0;
        #1;
        chk("R9 refresh first", cyc_kind, 2);
        word();
        chk("R9 idle after ref", bgnt, 0);
        chk("R9 access waits for breq", req_ready, 0);
        step();
        #1;
        chk("R9 bus second", bgnt, 1);
        breq = 1'b0;
        step();
        #1;
        chk("R9 bus released", bgnt, 0);
        chk("R3 request still pending", req_ready, 1);
        step();
        req_valid = 1'b0;
        #1;
        chk("R9 access last", cyc_kind, 1);
        word();

        // R1 power-on mid-burst, then R2/R3 with a held request
        start_acc(1'b1);
        word();
        por_cycle(1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule